// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns the postbyte of an indexed operand, plus up to two extension bytes, into a 16-bit effective address. The postbyte selects one of several forms. The first is a short signed offset from one of four base registers (X, Y, SP, PC). The second is an automatic pre- or post-modify of a base register by a step of -8..-1 or +1..+8. The third is an 8-bit or 16-bit constant offset. The fourth adds accumulator A, B or D to a base register. The last two are indirect forms, which read a 16-bit pointer from memory and use it as the address.

The sequencer accepts a postbyte on `start` while idle. It pulls extension bytes over a valid/ready fetch port and reads pointer bytes over a request/acknowledge memory port. When the work is finished it pulses `done` for one cycle, together with the address, an optional base-register write-back, an illegal flag and an extra-cycle count. A restrict input forbids the constant-offset and indirect forms. The block holds no register file of its own: it takes register values as inputs and reports write-backs to the owner of those registers.

Top module: `idx_addr_gen`

## Requirements
- R1: When postbyte bit 5 is 0, the base is selected by bits 7:6 (0=X, 1=Y, 2=SP, 3=PC). The address is base plus bits 4:0 read as a 5-bit two's-complement value. There is no write-back and the extra count is 0.
- R2: When bit 5 is 1 and bits 7:6 are not 11, the form is auto-modify on the register in bits 7:6. If bit 3 is set, the step is bits 3:0 sign-extended (-8..-1). Otherwise the step is bits 2:0 plus 1 (1..8).
- R3: An auto-modify form always writes back base+step, with `wb_sel` equal to bits 7:6. The address is base+step when bit 4 is 0, and the unmodified base when bit 4 is 1. The extra count is 0.
- R4: When bits 7:6 are 11, bit 5 is 1, bit 2 is 0 and bits 2:0 are not 011, the form is a constant offset from the register in bits 4:3. If bit 1 is 1, two extension bytes form a 16-bit offset, with the high byte first. If bit 1 is 0, one byte is used, and bit 0 supplies its upper 8 bits (0xFF when set). The extra count is 1.
- R5: When bits 7:6 are 11, bit 5 is 1 and bits 2:0 are 011, two extension bytes (high first) are added to the register in bits 4:3. The block then reads the byte at that sum as the high byte of the address and the byte at sum+1 as the low byte. The extra count is 1.
- R6: When bits 7:6 are 11, bit 5 is 1 and bit 2 is 1, bits 1:0 choose the offset added to the register in bits 4:3. The choices are 00 for zero-extended A, 01 for zero-extended B, and 10 for D={A,B}, each with an extra count of 0. The choice 11 adds D, reads a big-endian pointer from that sum as in R5, and has an extra count of 1.
- R7: With `restrict_i` high, the forms of R4, R5 and the indirect case of R6 complete with address 0, `illegal` high, no write-back and an extra count of 0. They make no extension fetch and no memory read.
- R8: All address sums and write-back values wrap modulo 2^16.
- R9: Each accepted postbyte produces exactly one one-cycle `done` pulse. A `start` seen while a postbyte is in progress is ignored.
- R10: An extension byte is consumed only in a cycle with `ext_valid` and `ext_ready` both high. `ext_ready` stays high until that happens, and is never high together with `mem_req`.
- R11: `mem_req` and `mem_addr` hold steady until `mem_ack`. The pointer's second read follows at the next address.
- R12: During reset, `done`, `wb_en`, `illegal`, `ext_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Postbyte present (taken only when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| restrict_i | input | 1 | Forbid constant-offset and indirect forms |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| ext_valid | input | 1 | Extension byte available |
| ext_data | input | 8 | Extension byte |
| ext_ready | output | 1 | Block waits for an extension byte |
| mem_ack | input | 1 | Memory read completes |
| mem_rdata | input | 8 | Byte read from memory |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address (valid with done) |
| wb_en | output | 1 | Base register write-back (with done) |
| wb_sel | output | 2 | Register to write back (0=X,1=Y,2=SP,3=PC) |
| wb_val | output | 16 | Write-back value |
| illegal | output | 1 | Form forbidden under restrict (with done) |
| extra_cyc | output | 2 | Extra cycles charged for the form |

## Verification
On every cycle, the assertions check that done is a single-cycle pulse and that write-back and illegal appear only with done. They also check that an illegal completion reports address 0 with no write-back, that the two ports are never active together, that a stalled request or fetch holds, and that the second pointer read targets the next address. The decode of all 256 postbytes under both restrict settings can only be shown by the bench's sweep. So can the arithmetic of each offset form, the wrap at 2^16, the byte order of extension and pointer reads, and the rejection of a second start while busy. The sweep runs against two register sets and compares each result with an arithmetic model.

// File: rtl/idx_addr_pkg.sv
// Shared types for the indexed postbyte address generator.
// Assumes an 8-bit postbyte and four selectable base registers.
package idx_addr_pkg;

    typedef enum logic [3:0] {
        MD_SHORT,
        MD_AUTO,
        MD_CONST8,
        MD_CONST16,
        MD_IND16,
        MD_ACC_A,
        MD_ACC_B,
        MD_ACC_D,
        MD_IND_D
    } idx_mode_e;

    typedef struct packed {
        idx_mode_e  mode;
        logic [1:0] base_sel;
        logic [1:0] ext_cnt;
        logic       mem_rd;
        logic       forbid;
        logic       extra;
    } idx_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT_HI,
        ST_EXT_LO,
        ST_MEM_HI,
        ST_MEM_LO
    } idx_state_e;

endpackage

// File: rtl/idx_postbyte_dec.sv
// Postbyte decoder: classifies the postbyte into an addressing form.
// It selects the base register and reports how many extension bytes and
// memory reads the form needs. Purely combinational; the restrict flag
// turns the constant and indirect forms into forbidden ones.
module idx_postbyte_dec
    import idx_addr_pkg::*;
(
    input  logic [7:0] pb,
    input  logic       restrict_i,
    output idx_dec_t   dec
);

    // Decode priority: short, auto-modify, indirect-16, constant, accumulator.
    always_comb begin
        dec          = '0;
        dec.mode     = MD_SHORT;
        dec.base_sel = pb[7:6];
        if (!pb[5]) begin
            dec.mode = MD_SHORT;
        end else if (pb[7:6] != 2'b11) begin
            dec.mode = MD_AUTO;
        end else begin
            dec.base_sel = pb[4:3];
            if (pb[2:0] == 3'b011) begin
                dec.mode    = MD_IND16;
                dec.ext_cnt = 2'd2;
                dec.mem_rd  = 1'b1;
                dec.extra   = 1'b1;
                dec.forbid  = restrict_i;
            end else if (!pb[2]) begin
                dec.mode    = pb[1] ? MD_CONST16 : MD_CONST8;
                dec.ext_cnt = pb[1] ? 2'd2 : 2'd1;
                dec.extra   = 1'b1;
                dec.forbid  = restrict_i;
            end else begin
                unique case (pb[1:0])
                    2'b00: dec.mode = MD_ACC_A;
                    2'b01: dec.mode = MD_ACC_B;
                    2'b10: dec.mode = MD_ACC_D;
                    default: begin
                        dec.mode   = MD_IND_D;
                        dec.mem_rd = 1'b1;
                        dec.extra  = 1'b1;
                        dec.forbid = restrict_i;
                    end
                endcase
            end
        end
        if (dec.forbid) begin
            dec.ext_cnt = 2'd0;
            dec.mem_rd  = 1'b0;
            dec.extra   = 1'b0;
        end
    end

endmodule

// File: rtl/idx_base_mux.sv
// Base register selector: picks one of NREG register values by index.
// Assumes index 0..NREG-1 in the order X, Y, SP, PC.
module idx_base_mux #(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][AW-1:0] regs,
    input  logic [SW-1:0]           sel,
    output logic [AW-1:0]           base
);

    // AND-OR selection, one term per register.
    always_comb begin
        base = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SW'(i)) base = base | regs[i];
        end
    end

endmodule

// File: rtl/idx_offset_calc.sv
// Offset former and adder: builds the offset for the decoded form and
// adds it to the base, wrapping at the address width.
// Assumes AW equals two extension bytes (AW == 2*BW).
module idx_offset_calc
    import idx_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  idx_mode_e         mode,
    input  logic [4:0]        pb_lo,
    input  logic [AW-1:0]     base,
    input  logic [BW-1:0]     acc_a,
    input  logic [BW-1:0]     acc_b,
    input  logic [BW-1:0]     ext_hi,
    input  logic [BW-1:0]     ext_lo,
    output logic [AW-1:0]     sum
);

    logic [AW-1:0] off;

    // Offset per addressing form.
    always_comb begin
        unique case (mode)
            MD_SHORT:   off = {{(AW-5){pb_lo[4]}}, pb_lo[4:0]};
            MD_AUTO:    off = pb_lo[3] ? {{(AW-4){1'b1}}, pb_lo[3:0]}
                                       : AW'(pb_lo[2:0]) + AW'(1);
            MD_CONST8:  off = {{(AW-BW){pb_lo[0]}}, ext_lo};
            MD_CONST16,
            MD_IND16:   off = AW'({ext_hi, ext_lo});
            MD_ACC_A:   off = AW'(acc_a);
            MD_ACC_B:   off = AW'(acc_b);
            default:    off = AW'({acc_a, acc_b});
        endcase
    end

    // Modular address sum.
    assign sum = base + off;

endmodule

// File: rtl/idx_addr_gen.sv
// Indexed postbyte address generator (top).
// Accepts a postbyte while idle, gathers extension bytes and pointer
// bytes as the form requires, and completes with a one-cycle done pulse.
// Assumes register and accumulator inputs stay stable until done, except
// that the selected base is captured when the postbyte is taken.
module idx_addr_gen
    import idx_addr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int BW    = 8,
    parameter int CYC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BW-1:0]    postbyte,
    input  logic             restrict_i,
    input  logic [AW-1:0]    reg_x,
    input  logic [AW-1:0]    reg_y,
    input  logic [AW-1:0]    reg_sp,
    input  logic [AW-1:0]    reg_pc,
    input  logic [BW-1:0]    acc_a,
    input  logic [BW-1:0]    acc_b,
    input  logic             ext_valid,
    input  logic [BW-1:0]    ext_data,
    output logic             ext_ready,
    input  logic             mem_ack,
    input  logic [BW-1:0]    mem_rdata,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             done,
    output logic [AW-1:0]    eff_addr,
    output logic             wb_en,
    output logic [1:0]       wb_sel,
    output logic [AW-1:0]    wb_val,
    output logic             illegal,
    output logic [CYC_W-1:0] extra_cyc
);

    localparam int NREG = 4;

    idx_state_e    st_q, st_d;
    logic [BW-1:0] pb_q, ext_hi_q, rd_hi_q;
    logic          rs_q;
    logic [AW-1:0] base_q, ptr_q;
    logic          idle;
    logic [BW-1:0] pb_cur;
    logic          rs_cur;
    idx_dec_t      dec;
    logic [NREG-1:0][AW-1:0] regs_arr;
    logic [AW-1:0] base_live, base_cur, sum;
    logic          ext_take, mem_take;
    logic          fin, fin_ill, fin_wb, ptr_ld;
    logic [AW-1:0] fin_ea;

    logic             done_q, wb_en_q, ill_q;
    logic [AW-1:0]    ea_q, wb_val_q;
    logic [1:0]       wb_sel_q;
    logic [CYC_W-1:0] extra_q;

    // Live postbyte when idle, captured postbyte while busy.
    assign idle   = (st_q == ST_IDLE);
    assign pb_cur = idle ? postbyte : pb_q;
    assign rs_cur = idle ? restrict_i : rs_q;

    idx_postbyte_dec u_dec (
        .pb         (pb_cur),
        .restrict_i (rs_cur),
        .dec        (dec)
    );

    // Register order seen by the selector: X, Y, SP, PC.
    assign regs_arr = {reg_pc, reg_sp, reg_y, reg_x};

    idx_base_mux #(.AW(AW), .NREG(NREG)) u_mux (
        .regs (regs_arr),
        .sel  (dec.base_sel),
        .base (base_live)
    );

    assign base_cur = idle ? base_live : base_q;

    idx_offset_calc #(.AW(AW), .BW(BW)) u_calc (
        .mode   (dec.mode),
        .pb_lo  (pb_cur[4:0]),
        .base   (base_cur),
        .acc_a  (acc_a),
        .acc_b  (acc_b),
        .ext_hi (ext_hi_q),
        .ext_lo (ext_data),
        .sum    (sum)
    );

    // Port controls follow the state directly.
    assign ext_ready = (st_q == ST_EXT_HI) || (st_q == ST_EXT_LO);
    assign mem_req   = (st_q == ST_MEM_HI) || (st_q == ST_MEM_LO);
    assign mem_addr  = (st_q == ST_MEM_LO) ? ptr_q + AW'(1) : ptr_q;
    assign ext_take  = ext_ready && ext_valid;
    assign mem_take  = mem_req && mem_ack;

    // Next state and completion terms.
    always_comb begin
        st_d    = st_q;
        fin     = 1'b0;
        fin_ea  = sum;
        fin_ill = 1'b0;
        fin_wb  = 1'b0;
        ptr_ld  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (dec.forbid) begin
                        fin     = 1'b1;
                        fin_ill = 1'b1;
                        fin_ea  = '0;
                    end else if (dec.ext_cnt == 2'd2) begin
                        st_d = ST_EXT_HI;
                    end else if (dec.ext_cnt == 2'd1) begin
                        st_d = ST_EXT_LO;
                    end else if (dec.mem_rd) begin
                        st_d   = ST_MEM_HI;
                        ptr_ld = 1'b1;
                    end else begin
                        fin    = 1'b1;
                        fin_wb = (dec.mode == MD_AUTO);
                        if (dec.mode == MD_AUTO && pb_cur[4]) fin_ea = base_cur;
                    end
                end
            end
            ST_EXT_HI: begin
                if (ext_take) st_d = ST_EXT_LO;
            end
            ST_EXT_LO: begin
                if (ext_take) begin
                    if (dec.mem_rd) begin
                        st_d   = ST_MEM_HI;
                        ptr_ld = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                        fin  = 1'b1;
                    end
                end
            end
            ST_MEM_HI: begin
                if (mem_take) st_d = ST_MEM_LO;
            end
            ST_MEM_LO: begin
                if (mem_take) begin
                    st_d   = ST_IDLE;
                    fin    = 1'b1;
                    fin_ea = AW'({rd_hi_q, mem_rdata});
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Sequencer state, captured operands and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            pb_q     <= '0;
            rs_q     <= 1'b0;
            base_q   <= '0;
            ptr_q    <= '0;
            ext_hi_q <= '0;
            rd_hi_q  <= '0;
            done_q   <= 1'b0;
            wb_en_q  <= 1'b0;
            ill_q    <= 1'b0;
            ea_q     <= '0;
            wb_sel_q <= '0;
            wb_val_q <= '0;
            extra_q  <= '0;
        end else begin
            st_q <= st_d;
            if (idle && start) begin
                pb_q   <= postbyte;
                rs_q   <= restrict_i;
                base_q <= base_live;
            end
            if (st_q == ST_EXT_HI && ext_take) ext_hi_q <= ext_data;
            if (ptr_ld) ptr_q <= sum;
            if (st_q == ST_MEM_HI && mem_take) rd_hi_q <= mem_rdata;
            done_q  <= fin;
            wb_en_q <= fin && fin_wb;
            ill_q   <= fin && fin_ill;
            if (fin) begin
                ea_q     <= fin_ea;
                wb_sel_q <= dec.base_sel;
                wb_val_q <= sum;
                extra_q  <= CYC_W'(dec.extra);
            end
        end
    end

    assign done      = done_q;
    assign eff_addr  = ea_q;
    assign wb_en     = wb_en_q;
    assign wb_sel    = wb_sel_q;
    assign wb_val    = wb_val_q;
    assign illegal   = ill_q;
    assign extra_cyc = extra_q;

endmodule

// File: rtl/idx_addr_gen_chk.sv
// Property checker for idx_addr_gen, attached by bind below.
// Observes the block's ports only.
module idx_addr_gen_chk #(
    parameter int AW    = 16,
    parameter int CYC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_valid,
    input logic             ext_ready,
    input logic             mem_ack,
    input logic             mem_req,
    input logic [AW-1:0]    mem_addr,
    input logic             done,
    input logic [AW-1:0]    eff_addr,
    input logic             wb_en,
    input logic             illegal,
    input logic [CYC_W-1:0] extra_cyc
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R7
    illegal_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && eff_addr == '0 && !wb_en && extra_cyc == '0));

    // R10
    ports_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_ready && mem_req));

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ready && !ext_valid) |=> ext_ready);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R11
    next_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == AW'($past(mem_addr) + AW'(1))));

    // R4
    extra_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (extra_cyc <= CYC_W'(1)));

endmodule

bind idx_addr_gen idx_addr_gen_chk #(.AW(AW), .CYC_W(CYC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_valid (ext_valid),
    .ext_ready (ext_ready),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .done      (done),
    .eff_addr  (eff_addr),
    .wb_en     (wb_en),
    .illegal   (illegal),
    .extra_cyc (extra_cyc)
);

// File: tb/idx_addr_gen_tb.sv
// Sweep bench: all postbytes, both restrict settings, two register sets,
// with stalling fetch and memory responders and an arithmetic model.
module idx_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic        restrict_i = 1'b0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_data = '0;
    logic        ext_ready;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        done;
    logic [15:0] eff_addr;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_val;
    logic        illegal;
    logic [1:0]  extra_cyc;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0]  e1, e2, cur_pb;
    logic        cur_rs;
    int          ext_n, rd_n;
    logic [15:0] rd_addr [0:3];
    logic        tog = 1'b0;
    logic        rdy_last = 1'b0, req_last = 1'b0;
    logic [15:0] addr_last = '0;

    always #5 clk = ~clk;

    idx_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .restrict_i(restrict_i), .reg_x(reg_x), .reg_y(reg_y),
        .reg_sp(reg_sp), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
        .ext_valid(ext_valid), .ext_data(ext_data), .ext_ready(ext_ready),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .done(done), .eff_addr(eff_addr),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
        .illegal(illegal), .extra_cyc(extra_cyc)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] regsel(input logic [1:0] s);
        case (s)
            2'd0: return reg_x;
            2'd1: return reg_y;
            2'd2: return reg_sp;
            default: return reg_pc;
        endcase
    endfunction

    // Fetch and memory responders; handshakes are counted one edge late.
    always @(negedge clk) begin
        if (ext_valid && rdy_last) ext_n = ext_n + 1;
        if (mem_ack && req_last) begin
            if (rd_n < 4) rd_addr[rd_n] = addr_last;
            rd_n = rd_n + 1;
        end
        tog       = ~tog;
        rdy_last  = ext_ready;
        req_last  = mem_req;
        addr_last = mem_addr;
        ext_valid = tog;
        ext_data  = (ext_n == 0) ? e1 : e2;
        mem_ack   = mem_req && !tog;
        mem_rdata = mbyte(mem_addr);
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s pb=%02h rs=%0d act=%04h exp=%04h",
                     tag, what, cur_pb, cur_rs, act, exp);
        end
    endtask

    task automatic do_op(input logic [7:0] pb, input logic rs, input bit wrapset,
                         input bit busy_poke);
        logic [15:0] b, step, x_ea, x_wbv, x_ptr;
        logic        x_ill, x_wb, x_mem, x_extra, seen;
        logic [1:0]  x_sel;
        int          x_ext;
        string       tg;
        e1 = pb ^ 8'hC3;
        e2 = pb + 8'h37;
        cur_pb = pb; cur_rs = rs;
        x_ea = '0; x_wbv = '0; x_ptr = '0; x_ill = 0; x_wb = 0; x_mem = 0;
        x_extra = 0; x_sel = '0; x_ext = 0;
        // Reference model from the requirements
        if (!pb[5]) begin
            tg = "R1";
            x_ea = regsel(pb[7:6]) + {{11{pb[4]}}, pb[4:0]};
        end else if (pb[7:6] != 2'b11) begin
            tg = "R2";
            b = regsel(pb[7:6]);
            step = pb[3] ? {12'hFFF, pb[3:0]} : ({13'd0, pb[2:0]} + 16'd1);
            x_wb = 1; x_sel = pb[7:6]; x_wbv = b + step;
            x_ea = pb[4] ? b : b + step;
        end else begin
            b = regsel(pb[4:3]);
            if (pb[2:0] == 3'b011) begin
                tg = "R5";
                if (rs) x_ill = 1;
                else begin x_ext = 2; x_mem = 1; x_extra = 1; x_ptr = b + {e1, e2}; end
            end else if (!pb[2]) begin
                tg = "R4";
                if (rs) x_ill = 1;
                else begin
                    x_extra = 1;
                    if (pb[1]) begin x_ext = 2; x_ea = b + {e1, e2}; end
                    else begin x_ext = 1; x_ea = b + {{8{pb[0]}}, e1}; end
                end
            end else begin
                tg = "R6";
                case (pb[1:0])
                    2'b00: x_ea = b + {8'h00, acc_a};
                    2'b01: x_ea = b + {8'h00, acc_b};
                    2'b10: x_ea = b + {acc_a, acc_b};
                    default: begin
                        if (rs) x_ill = 1;
                        else begin x_mem = 1; x_extra = 1; x_ptr = b + {acc_a, acc_b}; end
                    end
                endcase
            end
        end
        if (x_mem) x_ea = {mbyte(x_ptr), mbyte(x_ptr + 16'd1)};
        if (x_ill) tg = "R7";
        else if (wrapset) tg = "R8";

        @(negedge clk);
        ext_n = 0; rd_n = 0;
        start = 1'b1; postbyte = pb; restrict_i = rs;
        @(negedge clk);
        if (busy_poke) begin
            postbyte = 8'h00;
            @(negedge clk);
        end
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 64; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, "R9", "done seen", 16'(seen), 16'd1);
        if (seen) begin
            chk(eff_addr == x_ea, tg, "address", eff_addr, x_ea);
            chk(illegal == x_ill, x_ill ? "R7" : tg, "illegal", 16'(illegal), 16'(x_ill));
            chk(wb_en == x_wb, x_wb ? "R3" : tg, "wb_en", 16'(wb_en), 16'(x_wb));
            if (x_wb) begin
                chk(wb_sel == x_sel, "R3", "wb_sel", 16'(wb_sel), 16'(x_sel));
                chk(wb_val == x_wbv, "R3", "wb_val", wb_val, x_wbv);
            end
            chk(extra_cyc == 2'(x_extra), tg, "extra", 16'(extra_cyc), 16'(x_extra));
            @(negedge clk);
            chk(!done, "R9", "done single cycle", 16'(done), 16'd0);
            chk(ext_n == x_ext, x_ill ? "R7" : "R10", "ext bytes", 16'(ext_n), 16'(x_ext));
            chk(rd_n == (x_mem ? 2 : 0), x_ill ? "R7" : "R11", "mem reads",
                16'(rd_n), x_mem ? 16'd2 : 16'd0);
            if (x_mem && rd_n == 2) begin
                chk(rd_addr[0] == x_ptr, "R5", "pointer high addr", rd_addr[0], x_ptr);
                chk(rd_addr[1] == x_ptr + 16'd1, "R5", "pointer low addr",
                    rd_addr[1], x_ptr + 16'd1);
            end
            if (busy_poke) begin
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    chk(!done, "R9", "ignored start", 16'(done), 16'd0);
                end
            end
        end
    endtask

    initial begin
        cur_pb = '0; cur_rs = 0; e1 = '0; e2 = '0; ext_n = 0; rd_n = 0;
        repeat (3) @(negedge clk);
        chk(!done && !wb_en && !illegal, "R12", "outputs in reset",
            {13'd0, done, wb_en, illegal}, 16'd0);
        chk(!ext_ready && !mem_req, "R12", "ports in reset",
            {14'd0, ext_ready, mem_req}, 16'd0);
        rst_n = 1'b1;
        // Set 0: no wrap expected for most forms
        reg_x = 16'h1000; reg_y = 16'h2345; reg_sp = 16'h3FF0; reg_pc = 16'hC000;
        acc_a = 8'h12; acc_b = 8'h80;
        for (int r = 0; r < 2; r++)
            for (int p = 0; p < 256; p++)
                do_op(8'(p), r[0], 1'b0, 1'b0);
        // Set 1: values near the ends of the address space
        reg_x = 16'hFFF8; reg_y = 16'h0005; reg_sp = 16'hFFFF; reg_pc = 16'h0001;
        acc_a = 8'hF0; acc_b = 8'h9C;
        for (int r = 0; r < 2; r++)
            for (int p = 0; p < 256; p++)
                do_op(8'(p), r[0], 1'b1, 1'b0);
        // Second start while a constant-16 form waits for bytes
        do_op(8'hE2, 1'b0, 1'b1, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule